// File: doc/BRIEF.md
# DMA Event-Interrupt Resource Controller

This block keeps the event-interrupt resources of a multi-channel DMA engine: eight numbered resources (indices 0 to 7) and one abort resource (index 8). Each resource has a mode bit. With the bit clear, a signal command raises an internal event. The event is broadcast to every channel thread and is consumed by a wait. With the bit set, the same command raises an external interrupt line. That line stays high until software clears it.

Channel threads issue wait requests. A thread waiting on a resource whose event is inactive parks in a per-channel waiting register. It is released on the clock edge after the event becomes active, and that edge also consumes the event. Software can clear interrupt lines, rewrite the mode vector, and read raw status (event or line active) and interrupt status (line high). Signal, clear and wait requests are single-cycle strobes that carry a resource index. The abort resource is raised only by a separate fault strobe; a software signal that names index 8 or higher is rejected.

Top module: `dma_evt_irq_ctrl`

## Requirements
- R1: After reset all events are inactive, all interrupt lines are low, every mode bit is 0 (event mode), no channel is waiting and the bad-argument flag is low.
- R2: A software signal on index n (0..7) whose mode bit is 0 makes rawStat[n] high on the next clock edge and leaves irq[n] low.
- R3: A signal on a resource whose mode bit is 1 makes irq[n] high on the next clock edge.
- R4: Once high, irq[n] stays high across any number of idle cycles and falls only on the edge after a clear request for n that is accepted.
- R5: A clear request has no effect on irq[n] when the mode bit of n is 0, or when irq[n] is already low.
- R6: A wait from channel c on a resource whose event is inactive sets chanWaiting[c]. Every channel waiting on n is released (chanWaiting drops) on the edge after the event for n becomes active, and the event clears on that same edge.
- R7: A wait on a resource whose event is already active consumes the event on the next edge, and the channel does not enter the waiting state.
- R8: A software signal with an index of 8 or more changes no event or line, and badArg is high for exactly the following cycle. The fault strobe is the only way to raise the abort resource (index 8), and it follows that resource's mode bit.
- R9: When a signal and a clear or wait for the same resource arrive in the same cycle, the signal wins and the resource stays set.
- R10: Rewriting the mode vector leaves pending events and lines unchanged. The new mode applies only to later signals.
- R11: rawStat[n] is the OR of the event and the line of n. irq[n] reflects the line alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigValid | input | 1 | Software signal strobe |
| sigIdx | input | 4 | Resource index of the signal |
| faultSig | input | 1 | Fault strobe that raises the abort resource |
| clrValid | input | 1 | Interrupt clear strobe |
| clrIdx | input | 4 | Resource index to clear |
| waitValid | input | 1 | Channel wait strobe |
| waitCh | input | 2 | Channel issuing the wait |
| waitIdx | input | 4 | Resource index waited on |
| enWe | input | 1 | Mode vector write strobe |
| enData | input | 9 | New mode vector, bit n = 1 selects interrupt mode for resource n |
| irq | output | 9 | Interrupt lines / interrupt status |
| rawStat | output | 9 | Raw status: event active or line high |
| chanWaiting | output | 4 | Channel c is parked on a wait |
| badArg | output | 1 | Previous cycle's software signal named an invalid index |

## Verification
Every numbered resource is signalled once in event mode and once in interrupt mode, and each resulting one-hot status is checked against a shifted 1. This shows that the index decoding and the mode routing are separate. A parked wait and an immediate wait are both run, so release timing is told apart from direct consumption. Several channels are also parked on one resource while another channel is parked on a different one, which shows that the broadcast release hits exactly the matching threads. Collision, mode-switch and invalid-index patterns each pair a stimulus with a readback at the ports. These patterns separate "signal wins" from "clear wins", and "pending state kept" from "pending state remapped".

// File: rtl/dma_evt_irq_pkg.sv
package dma_evt_irq_pkg;
  localparam int NUM_EVT   = 8;
  localparam int NRES      = NUM_EVT + 1;
  localparam int ABORT_IDX = NUM_EVT;
  localparam int NUM_CH    = 4;
  localparam int IDXW      = $clog2(NRES);
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef struct packed {
    logic [NRES-1:0] setEvt;
    logic [NRES-1:0] setIrq;
    logic [NRES-1:0] clrIrq;
    logic            waitReq;
    logic [CHW-1:0]  waitCh;
    logic [IDXW-1:0] waitIdx;
  } evtCmd_t;
endpackage

// File: rtl/dma_evt_irq_ctl.sv
module dma_evt_irq_ctl
  import dma_evt_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sigValid,
  input  logic [IDXW-1:0] sigIdx,
  input  logic            faultSig,
  input  logic            clrValid,
  input  logic [IDXW-1:0] clrIdx,
  input  logic            waitValid,
  input  logic [CHW-1:0]  waitCh,
  input  logic [IDXW-1:0] waitIdx,
  input  logic            enWe,
  input  logic [NRES-1:0] enData,
  output evtCmd_t         cmd,
  output logic            badArg
);
  logic [NRES-1:0] modeReg;
  logic [NRES-1:0] sigHot;
  logic [NRES-1:0] clrHot;

  // numbered resources come from software; the abort slot only from the fault strobe
  for (genvar g = 0; g < NRES; g++) begin : g_hot
    if (g < NUM_EVT) begin : g_num
      assign sigHot[g] = sigValid && (sigIdx == IDXW'(g));
    end else begin : g_abort
      assign sigHot[g] = faultSig;
    end
    assign clrHot[g] = clrValid && (clrIdx == IDXW'(g));
  end

  always_comb begin
    cmd.setEvt  = sigHot & ~modeReg;
    cmd.setIrq  = sigHot & modeReg;
    cmd.clrIrq  = clrHot & modeReg;
    cmd.waitReq = waitValid && (waitIdx < IDXW'(NRES));
    cmd.waitCh  = waitCh;
    cmd.waitIdx = waitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      badArg  <= 1'b0;
    end else begin
      if (enWe) modeReg <= enData;
      badArg <= sigValid && (sigIdx >= IDXW'(NUM_EVT));
    end
  end

  // R8: a rejected software index raises nothing
  p_reject_idx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && (sigIdx >= IDXW'(NUM_EVT)) && !faultSig)
      |-> (cmd.setEvt == '0 && cmd.setIrq == '0));
endmodule

// File: rtl/dma_evt_irq_dp.sv
module dma_evt_irq_dp
  import dma_evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  evtCmd_t           cmd,
  output logic [NRES-1:0]   evtQ,
  output logic [NRES-1:0]   irqQ,
  output logic [NUM_CH-1:0] chanWaiting
);
  logic [NUM_CH-1:0]           waiting;
  logic [NUM_CH-1:0][IDXW-1:0] wIdx;
  logic [NRES-1:0]             waitMask;
  logic [NRES-1:0]             release_;
  logic [NRES-1:0]             consume;
  logic                        chBusy;
  logic                        evtHit;

  always_comb begin
    waitMask = '0;
    for (int n = 0; n < NRES; n++)
      for (int c = 0; c < NUM_CH; c++)
        if (waiting[c] && wIdx[c] == IDXW'(n)) waitMask[n] = 1'b1;
  end

  assign release_ = evtQ & waitMask;
  assign chBusy   = waiting[cmd.waitCh];
  assign evtHit   = cmd.waitReq && evtQ[cmd.waitIdx];

  always_comb begin
    consume = '0;
    for (int n = 0; n < NRES; n++)
      if (evtHit && !chBusy && cmd.waitIdx == IDXW'(n)) consume[n] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ    <= '0;
      irqQ    <= '0;
      waiting <= '0;
      wIdx    <= '0;
    end else begin
      evtQ <= (evtQ & ~(release_ | consume)) | cmd.setEvt;
      irqQ <= (irqQ & ~cmd.clrIrq) | cmd.setIrq;
      for (int c = 0; c < NUM_CH; c++) begin
        if (waiting[c] && evtQ[wIdx[c]]) begin
          waiting[c] <= 1'b0;
        end else if (cmd.waitReq && cmd.waitCh == CHW'(c) && !waiting[c] && !evtHit) begin
          waiting[c] <= 1'b1;
          wIdx[c]    <= cmd.waitIdx;
        end
      end
    end
  end

  assign chanWaiting = waiting;

  for (genvar g = 0; g < NRES; g++) begin : g_res_chk
    // R3: an interrupt-mode signal raises the line
    p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
      cmd.setIrq[g] |=> irqQ[g]);
    // R4: a line only falls after an accepted clear
    p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqQ[g]) |-> $past(cmd.clrIrq[g]));
    // R7: an event only drops because a wait consumed it
    p_evt_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(evtQ[g]) |-> $past(waitMask[g] || (cmd.waitReq && cmd.waitIdx == IDXW'(g))));
    // R9: an event-mode signal always leaves the event set
    p_sig_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      cmd.setEvt[g] |=> evtQ[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    // R6: a parked thread leaves on the edge after its event is active
    p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
      (waiting[c] && evtQ[wIdx[c]]) |=> !waiting[c]);
  end
endmodule

// File: rtl/dma_evt_irq_ctrl.sv
module dma_evt_irq_ctrl
  import dma_evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigValid,
  input  logic [IDXW-1:0]   sigIdx,
  input  logic              faultSig,
  input  logic              clrValid,
  input  logic [IDXW-1:0]   clrIdx,
  input  logic              waitValid,
  input  logic [CHW-1:0]    waitCh,
  input  logic [IDXW-1:0]   waitIdx,
  input  logic              enWe,
  input  logic [NRES-1:0]   enData,
  output logic [NRES-1:0]   irq,
  output logic [NRES-1:0]   rawStat,
  output logic [NUM_CH-1:0] chanWaiting,
  output logic              badArg
);
  evtCmd_t         cmd;
  logic [NRES-1:0] evtQ;
  logic [NRES-1:0] irqQ;

  dma_evt_irq_ctl i_ctl (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigIdx(sigIdx),
    .faultSig(faultSig), .clrValid(clrValid), .clrIdx(clrIdx),
    .waitValid(waitValid), .waitCh(waitCh), .waitIdx(waitIdx),
    .enWe(enWe), .enData(enData), .cmd(cmd), .badArg(badArg)
  );

  dma_evt_irq_dp i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .evtQ(evtQ), .irqQ(irqQ), .chanWaiting(chanWaiting)
  );

  assign irq     = irqQ;
  assign rawStat = evtQ | irqQ;
endmodule

// File: tb/test_dma_evt_irq_ctrl.sv
module test_dma_evt_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sigValid = 0, faultSig = 0, clrValid = 0, waitValid = 0, enWe = 0;
  logic [3:0] sigIdx = 0, clrIdx = 0, waitIdx = 0;
  logic [1:0] waitCh = 0;
  logic [8:0] enData = 0;
  logic [8:0] irq, rawStat;
  logic [3:0] chanWaiting;
  logic       badArg;
  int         nChk = 0, nBad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  dma_evt_irq_ctrl i_dma_evt_irq_ctrl (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigIdx(sigIdx),
    .faultSig(faultSig), .clrValid(clrValid), .clrIdx(clrIdx),
    .waitValid(waitValid), .waitCh(waitCh), .waitIdx(waitIdx),
    .enWe(enWe), .enData(enData), .irq(irq), .rawStat(rawStat),
    .chanWaiting(chanWaiting), .badArg(badArg)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes, return after the edge that registers them
  task automatic step(bit sv, int si, bit cv, int ci, bit wv, int wc, int wi, bit fs);
    sigValid = sv; sigIdx = 4'(si); clrValid = cv; clrIdx = 4'(ci);
    waitValid = wv; waitCh = 2'(wc); waitIdx = 4'(wi); faultSig = fs;
    @(negedge clk);
    sigValid = 0; clrValid = 0; waitValid = 0; faultSig = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic sig(int i); step(1, i, 0, 0, 0, 0, 0, 0); endtask
  task automatic clr(int i); step(0, 0, 1, i, 0, 0, 0, 0); endtask
  task automatic waitOn(int c, int i); step(0, 0, 0, 0, 1, c, i, 0); endtask
  task automatic setMode(logic [8:0] v);
    enWe = 1; enData = v; @(negedge clk); enWe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 raw", 32'(rawStat), 0);
    chk("R1 waiting", 32'(chanWaiting), 0);
    chk("R1 badArg", 32'(badArg), 0);

    // event mode sweep
    for (int n = 0; n < 8; n++) begin
      sig(n);
      chk("R2 raw", 32'(rawStat), 32'(1) << n);
      chk("R2 irq", 32'(irq), 0);
      waitOn(n % 4, n);
      chk("R7 raw after wait", 32'(rawStat), 0);
      chk("R7 not waiting", 32'(chanWaiting), 0);
    end

    // interrupt mode sweep
    setMode(9'h0FF);
    for (int n = 0; n < 8; n++) begin
      sig(n);
      chk("R3 irq", 32'(irq), 32'(1) << n);
      chk("R11 raw", 32'(rawStat), 32'(1) << n);
      idle(); idle(); idle();
      chk("R4 irq held", 32'(irq), 32'(1) << n);
      clr(n);
      chk("R4 irq cleared", 32'(irq), 0);
    end

    // clear without interrupt mode, clear of a low line, mode change
    sig(3);
    setMode(9'h000);
    chk("R10 irq kept", 32'(irq), 32'h8);
    clr(3);
    chk("R5 clear in event mode", 32'(irq), 32'h8);
    setMode(9'h0FF);
    clr(2);
    chk("R5 clear low line", 32'(irq), 32'h8);
    clr(3);
    chk("R4 accepted clear", 32'(irq), 0);

    setMode(9'h000);
    sig(1);
    setMode(9'h0FF);
    chk("R10 event kept", 32'(rawStat), 32'h2);
    chk("R11 irq only line", 32'(irq), 0);
    waitOn(0, 1);
    chk("R7 consumed", 32'(rawStat), 0);

    // invalid indices and abort resource
    setMode(9'h000);
    for (int i = 8; i < 16; i++) begin
      sig(i);
      chk("R8 badArg", 32'(badArg), 1);
      chk("R8 raw unchanged", 32'(rawStat), 0);
      chk("R8 irq unchanged", 32'(irq), 0);
    end
    idle();
    chk("R8 badArg drops", 32'(badArg), 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 abort event", 32'(rawStat), 32'h100);
    chk("R8 abort no irq", 32'(irq), 0);
    waitOn(2, 8);
    chk("R8 abort consumed", 32'(rawStat), 0);
    setMode(9'h100);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 abort irq", 32'(irq), 32'h100);
    clr(8);
    chk("R8 abort cleared", 32'(irq), 0);

    // broadcast release
    setMode(9'h000);
    waitOn(0, 5); waitOn(1, 5); waitOn(2, 5); waitOn(3, 2);
    chk("R6 parked", 32'(chanWaiting), 32'hF);
    sig(5);
    chk("R6 event set", 32'(rawStat), 32'h20);
    chk("R6 still parked", 32'(chanWaiting), 32'hF);
    idle();
    chk("R6 released", 32'(chanWaiting), 32'h8);
    chk("R6 event consumed", 32'(rawStat), 0);
    sig(2);
    idle();
    chk("R6 last released", 32'(chanWaiting), 0);
    chk("R6 last consumed", 32'(rawStat), 0);

    // collisions
    setMode(9'h010);
    sig(4);
    step(1, 4, 1, 4, 0, 0, 0, 0);
    chk("R9 signal beats clear", 32'(irq), 32'h10);
    clr(4);
    chk("R9 later clear", 32'(irq), 0);
    setMode(9'h000);
    sig(6);
    step(1, 6, 0, 0, 1, 0, 6, 0);
    chk("R9 signal beats wait", 32'(rawStat), 32'h40);
    chk("R9 wait not parked", 32'(chanWaiting), 0);
    waitOn(1, 6);
    chk("R9 later wait", 32'(rawStat), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule